// File: doc/BRIEF.md
# DMA Channel Register Bank

This block is the host-facing register bank of a multi-channel, descriptor-driven copy engine. A host slave port issues single-cycle read or write requests of 1, 2, 4 or 8 bytes. The block decodes each request into a channel window and a register within that window. It then updates or returns the addressed register and answers one cycle later with read data or an error pulse.

Each channel holds six registers: a control word with an interrupt-disable flag, a command byte, a 64-bit status word, a 64-bit descriptor chain pointer, a 64-bit completion pointer and a 32-bit error word. Command writes are turned into single-cycle start, append and reset strobes for the channel sequencer, each tagged with the channel index. The sequencer writes whole status words and sets error bits through its own side inputs.

Data always sits in the low-order bytes of the 64-bit write and read buses.

Top module: `dmac_regbank`

## Requirements
- R1: Address bits above bit 6 form a window number. Window 0 (addresses below 0x80) is unmapped. Window n selects channel n-1, and bits 6:0 select the register: control 0x00, command 0x04, status 0x08, chain pointer low 0x10, chain pointer high 0x14, completion pointer low 0x18, completion pointer high 0x1C, error 0x20. Any other offset is unmapped.
- R2: An access whose channel index is NUM_CH or more is an error and changes no register.
- R3: A byte count other than 1, 2, 4 or 8 is an error. Each register also requires its own size: control 2, command 1, status 8, error 4, pointer high halves 4, pointer low halves 4 or 8. An erroneous access raises `rsp_err` for one cycle with `rsp_rdata` zero and has no effect.
- R4: An 8-byte write at a pointer's low offset replaces all 64 bits. A 4-byte write there replaces bits 31:0 and keeps 63:32. A 4-byte write at the high offset replaces bits 63:32 and keeps 31:0. An 8-byte read at the low offset returns the full pointer, and a 4-byte read returns the addressed half.
- R5: Host writes to status are accepted without error and ignored. Status changes only through a sequencer update (`seq_stat_valid`) or a command.
- R6: A host write to the error register clears each bit that is 1 in the data. Error bits set by the sequencer in the same cycle stay set: the new value is (old AND NOT data) OR set bits.
- R7: Control bit 0 is interrupt-disable and resets to 1 (control resets to 0x0001). Writing 1 there clears it, and writing 0 keeps it. Bits 15:1 take the written data.
- R8: Command bit 0 is start, bit 1 append and bit 5 reset, with priority start > append > reset. One matching strobe is issued with `cmd_chan` one cycle after the write. Start forces status bits 2:0 to 0, and reset forces them to 3; this applies on top of a same-cycle sequencer status update. The command register keeps the last accepted byte.
- R9: A command byte with any of bits 2, 3 or 4 set (suspend, abort, resume) is an error: no strobe is issued and the command register is unchanged.
- R10: `rsp_valid` follows each request by exactly one cycle. After reset, all registers read zero except control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | Request present |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Byte address |
| host_bytes | input | 4 | Access size in bytes |
| host_wdata | input | 64 | Write data, right-justified |
| rsp_valid | output | 1 | Response strobe, one cycle after request |
| rsp_err | output | 1 | Access error pulse |
| rsp_rdata | output | 64 | Read data, right-justified, zero on error |
| cmd_start | output | 1 | Start strobe to sequencer |
| cmd_append | output | 1 | Append strobe to sequencer |
| cmd_reset | output | 1 | Reset strobe to sequencer |
| cmd_chan | output | CH_W | Channel index of the strobe |
| seq_stat_valid | input | 1 | Sequencer status update |
| seq_stat_chan | input | CH_W | Channel of the status update |
| seq_stat_data | input | 64 | New status word |
| seq_err_valid | input | 1 | Sequencer error-set request |
| seq_err_chan | input | CH_W | Channel of the error set |
| seq_err_bits | input | 32 | Error bits to set |

## Verification
Two pairs of functions can meet in one cycle. In the first, a host write-one-to-clear on the error word coincides with the sequencer setting error bits on the same channel. In the second, a host start command coincides with a sequencer status update. The bench provokes both by driving the sequencer inputs in the very cycle of the host write. It then reads the register back and compares it with (old AND NOT data) OR set bits, and with the update word whose low three bits are forced to 0.

// File: rtl/dmac_rb_pkg.sv
package dmac_rb_pkg;
  localparam int unsigned WIN_SHIFT = 7;

  typedef enum logic [3:0] {
    RS_NONE, RS_CTRL, RS_CMD, RS_STAT, RS_CHAIN_LO, RS_CHAIN_HI,
    RS_CMPL_LO, RS_CMPL_HI, RS_ERR
  } reg_sel_e;

  localparam logic [6:0] OFS_CTRL     = 7'h00;
  localparam logic [6:0] OFS_CMD      = 7'h04;
  localparam logic [6:0] OFS_STAT     = 7'h08;
  localparam logic [6:0] OFS_CHAIN_LO = 7'h10;
  localparam logic [6:0] OFS_CHAIN_HI = 7'h14;
  localparam logic [6:0] OFS_CMPL_LO  = 7'h18;
  localparam logic [6:0] OFS_CMPL_HI  = 7'h1C;
  localparam logic [6:0] OFS_ERR      = 7'h20;

  localparam int CMD_START   = 0;
  localparam int CMD_APPEND  = 1;
  localparam int CMD_SUSPEND = 2;
  localparam int CMD_ABORT   = 3;
  localparam int CMD_RESUME  = 4;
  localparam int CMD_RESET   = 5;

  localparam int          CTRL_IDIS = 0;
  localparam logic [15:0] CTRL_RST  = 16'h0001;

  localparam logic [2:0] XS_STARTED = 3'd0;
  localparam logic [2:0] XS_HALTED  = 3'd3;
endpackage

// File: rtl/dmac_rb_decode.sv
module dmac_rb_decode
  import dmac_rb_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 12,
  parameter int CH_W   = 2
) (
  input  logic              valid,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        bytes,
  input  logic [2:0]        cmd_unsup,
  output logic              hit,
  output logic              err,
  output logic [CH_W-1:0]   chan,
  output reg_sel_e          sel,
  output logic              wide
);
  localparam int WIN_W = ADDR_W - WIN_SHIFT;
  localparam logic [WIN_W-1:0] LAST_WIN = WIN_W'(NUM_CH);

  logic [WIN_W-1:0]     win;
  logic [WIN_SHIFT-1:0] ofs;
  logic                 size_legal, size_ok, win_ok, cmd_bad;

  assign win  = addr[ADDR_W-1:WIN_SHIFT];
  assign ofs  = addr[WIN_SHIFT-1:0];
  assign chan = CH_W'(win - 1'b1);
  assign wide = (bytes == 4'd8);

  // R3: general size legality
  assign size_legal = (bytes == 4'd1) || (bytes == 4'd2) ||
                      (bytes == 4'd4) || (bytes == 4'd8);
  // R1/R2: window 0 unmapped, windows beyond the channel count out of range
  assign win_ok = (win != '0) && (win <= LAST_WIN);

  // R1/R3: register select and per-register size rule
  always_comb begin
    sel     = RS_NONE;
    size_ok = 1'b0;
    case (ofs)
      OFS_CTRL:     begin sel = RS_CTRL;     size_ok = (bytes == 4'd2); end
      OFS_CMD:      begin sel = RS_CMD;      size_ok = (bytes == 4'd1); end
      OFS_STAT:     begin sel = RS_STAT;     size_ok = (bytes == 4'd8); end
      OFS_CHAIN_LO: begin sel = RS_CHAIN_LO; size_ok = (bytes == 4'd4) || wide; end
      OFS_CHAIN_HI: begin sel = RS_CHAIN_HI; size_ok = (bytes == 4'd4); end
      OFS_CMPL_LO:  begin sel = RS_CMPL_LO;  size_ok = (bytes == 4'd4) || wide; end
      OFS_CMPL_HI:  begin sel = RS_CMPL_HI;  size_ok = (bytes == 4'd4); end
      OFS_ERR:      begin sel = RS_ERR;      size_ok = (bytes == 4'd4); end
      default:      begin sel = RS_NONE;     size_ok = 1'b0; end
    endcase
  end

  // R9: suspend, abort and resume are rejected
  assign cmd_bad = write && (sel == RS_CMD) && (|cmd_unsup);

  assign err = valid && !(size_legal && win_ok && (sel != RS_NONE) && size_ok && !cmd_bad);
  assign hit = valid && !err;
endmodule

// File: rtl/dmac_rb_chan.sv
module dmac_rb_chan
  import dmac_rb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  reg_sel_e    sel,
  input  logic        wide,
  input  logic [63:0] wdata,
  input  logic        go_start,
  input  logic        go_reset,
  input  logic        st_upd_en,
  input  logic [63:0] st_upd_data,
  input  logic        err_set_en,
  input  logic [31:0] err_set_bits,
  output logic [15:0] ctrl_o,
  output logic [7:0]  cmd_o,
  output logic [63:0] stat_o,
  output logic [63:0] chain_o,
  output logic [63:0] cmpl_o,
  output logic [31:0] err_o
);
  logic [15:0] ctrl_q, ctrl_d;
  logic [7:0]  cmd_q, cmd_d;
  logic [63:0] stat_q, stat_d, chain_q, chain_d, cmpl_q, cmpl_d;
  logic [31:0] err_q, err_d;
  logic        ctrl_en, cmd_en, stat_en, chain_en, cmpl_en, err_en;

  // clock enables
  assign ctrl_en  = wr_en && (sel == RS_CTRL);
  assign cmd_en   = wr_en && (sel == RS_CMD);
  assign chain_en = wr_en && ((sel == RS_CHAIN_LO) || (sel == RS_CHAIN_HI));
  assign cmpl_en  = wr_en && ((sel == RS_CMPL_LO) || (sel == RS_CMPL_HI));
  assign err_en   = (wr_en && (sel == RS_ERR)) || err_set_en;
  assign stat_en  = st_upd_en || go_start || go_reset;

  // next-state
  always_comb begin
    ctrl_d = wdata[15:0];
    ctrl_d[CTRL_IDIS] = wdata[CTRL_IDIS] ? 1'b0 : ctrl_q[CTRL_IDIS];

    cmd_d = wdata[7:0];

    chain_d = chain_q;
    if (sel == RS_CHAIN_HI)  chain_d = {wdata[31:0], chain_q[31:0]};
    else if (wide)           chain_d = wdata;
    else                     chain_d = {chain_q[63:32], wdata[31:0]};

    cmpl_d = cmpl_q;
    if (sel == RS_CMPL_HI)   cmpl_d = {wdata[31:0], cmpl_q[31:0]};
    else if (wide)           cmpl_d = wdata;
    else                     cmpl_d = {cmpl_q[63:32], wdata[31:0]};

    err_d = err_q;
    if (wr_en && (sel == RS_ERR)) err_d = err_q & ~wdata[31:0];
    if (err_set_en)               err_d = err_d | err_set_bits;

    stat_d = stat_q;
    if (st_upd_en) stat_d = st_upd_data;
    if (go_start)      stat_d[2:0] = XS_STARTED;
    else if (go_reset) stat_d[2:0] = XS_HALTED;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= CTRL_RST;
      cmd_q   <= '0;
      stat_q  <= '0;
      chain_q <= '0;
      cmpl_q  <= '0;
      err_q   <= '0;
    end else begin
      if (ctrl_en)  ctrl_q  <= ctrl_d;
      if (cmd_en)   cmd_q   <= cmd_d;
      if (stat_en)  stat_q  <= stat_d;
      if (chain_en) chain_q <= chain_d;
      if (cmpl_en)  cmpl_q  <= cmpl_d;
      if (err_en)   err_q   <= err_d;
    end
  end

  assign ctrl_o  = ctrl_q;
  assign cmd_o   = cmd_q;
  assign stat_o  = stat_q;
  assign chain_o = chain_q;
  assign cmpl_o  = cmpl_q;
  assign err_o   = err_q;

  assert_stat_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_upd_en && !go_start && !go_reset) |=> $stable(stat_q));

  assert_err_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (sel == RS_ERR) && !err_set_en) |=> ((err_q & $past(wdata[31:0])) == 32'd0));

  assert_err_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_set_en |=> ((err_q & $past(err_set_bits)) == $past(err_set_bits)));

  assert_idis_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (sel == RS_CTRL) && !wdata[CTRL_IDIS]) |=> (ctrl_q[CTRL_IDIS] == $past(ctrl_q[CTRL_IDIS])));

  assert_hi_keeps_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (sel == RS_CHAIN_HI)) |=> (chain_q[31:0] == $past(chain_q[31:0])));

  assert_start_field_R8: assert property (@(posedge clk) disable iff (!rst_n)
    go_start |=> (stat_q[2:0] == XS_STARTED));
endmodule

// File: rtl/dmac_regbank.sv
module dmac_regbank
  import dmac_rb_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 12,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_valid,
  input  logic              host_write,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [3:0]        host_bytes,
  input  logic [63:0]       host_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [63:0]       rsp_rdata,
  output logic              cmd_start,
  output logic              cmd_append,
  output logic              cmd_reset,
  output logic [CH_W-1:0]   cmd_chan,
  input  logic              seq_stat_valid,
  input  logic [CH_W-1:0]   seq_stat_chan,
  input  logic [63:0]       seq_stat_data,
  input  logic              seq_err_valid,
  input  logic [CH_W-1:0]   seq_err_chan,
  input  logic [31:0]       seq_err_bits
);
  localparam int WIN_W = ADDR_W - WIN_SHIFT;
  localparam logic [WIN_W-1:0] LAST_WIN = WIN_W'(NUM_CH);

  // reset: asserted asynchronously, released on the clock
  logic rst_s1, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_q  <= rst_s1;
    end
  end

  logic            dec_hit, dec_err, dec_wide;
  logic [CH_W-1:0] dec_chan;
  reg_sel_e        dec_sel;

  dmac_rb_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CH_W(CH_W)) u_dec (
    .valid     (host_valid),
    .write     (host_write),
    .addr      (host_addr),
    .bytes     (host_bytes),
    .cmd_unsup ({host_wdata[CMD_RESUME], host_wdata[CMD_ABORT], host_wdata[CMD_SUSPEND]}),
    .hit       (dec_hit),
    .err       (dec_err),
    .chan      (dec_chan),
    .sel       (dec_sel),
    .wide      (dec_wide)
  );

  logic wr_hit, cmd_wr, start_d, append_d, reset_d;
  assign wr_hit   = dec_hit && host_write;
  assign cmd_wr   = wr_hit && (dec_sel == RS_CMD);
  // R8: priority start > append > reset
  assign start_d  = cmd_wr && host_wdata[CMD_START];
  assign append_d = cmd_wr && !host_wdata[CMD_START] && host_wdata[CMD_APPEND];
  assign reset_d  = cmd_wr && !host_wdata[CMD_START] && !host_wdata[CMD_APPEND] &&
                    host_wdata[CMD_RESET];

  logic [15:0] ctrl_a  [NUM_CH];
  logic [7:0]  cmd_a   [NUM_CH];
  logic [63:0] stat_a  [NUM_CH];
  logic [63:0] chain_a [NUM_CH];
  logic [63:0] cmpl_a  [NUM_CH];
  logic [31:0] err_a   [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic me;
    assign me = (dec_chan == CH_W'(c));
    dmac_rb_chan u_ch (
      .clk          (clk),
      .rst_n        (rst_q),
      .wr_en        (wr_hit && me),
      .sel          (dec_sel),
      .wide         (dec_wide),
      .wdata        (host_wdata),
      .go_start     (start_d && me),
      .go_reset     (reset_d && me),
      .st_upd_en    (seq_stat_valid && (seq_stat_chan == CH_W'(c))),
      .st_upd_data  (seq_stat_data),
      .err_set_en   (seq_err_valid && (seq_err_chan == CH_W'(c))),
      .err_set_bits (seq_err_bits),
      .ctrl_o       (ctrl_a[c]),
      .cmd_o        (cmd_a[c]),
      .stat_o       (stat_a[c]),
      .chain_o      (chain_a[c]),
      .cmpl_o       (cmpl_a[c]),
      .err_o        (err_a[c])
    );
  end

  // read mux
  logic [63:0] rd_d;
  always_comb begin
    rd_d = '0;
    if (dec_hit && !host_write) begin
      case (dec_sel)
        RS_CTRL:     rd_d = {48'd0, ctrl_a[dec_chan]};
        RS_CMD:      rd_d = {56'd0, cmd_a[dec_chan]};
        RS_STAT:     rd_d = stat_a[dec_chan];
        RS_CHAIN_LO: rd_d = dec_wide ? chain_a[dec_chan] : {32'd0, chain_a[dec_chan][31:0]};
        RS_CHAIN_HI: rd_d = {32'd0, chain_a[dec_chan][63:32]};
        RS_CMPL_LO:  rd_d = dec_wide ? cmpl_a[dec_chan] : {32'd0, cmpl_a[dec_chan][31:0]};
        RS_CMPL_HI:  rd_d = {32'd0, cmpl_a[dec_chan][63:32]};
        RS_ERR:      rd_d = {32'd0, err_a[dec_chan]};
        default:     rd_d = '0;
      endcase
    end
  end

  // response and strobe registers
  logic strobe_any;
  assign strobe_any = start_d || append_d || reset_d;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      rsp_valid  <= 1'b0;
      rsp_err    <= 1'b0;
      rsp_rdata  <= '0;
      cmd_start  <= 1'b0;
      cmd_append <= 1'b0;
      cmd_reset  <= 1'b0;
      cmd_chan   <= '0;
    end else begin
      rsp_valid  <= host_valid;
      rsp_err    <= dec_err;
      rsp_rdata  <= rd_d;
      cmd_start  <= start_d;
      cmd_append <= append_d;
      cmd_reset  <= reset_d;
      if (strobe_any) cmd_chan <= dec_chan;
    end
  end

  assert_err_zero_R3: assert property (@(posedge clk) disable iff (!rst_q)
    rsp_err |-> (rsp_rdata == 64'd0));

  assert_err_has_rsp_R10: assert property (@(posedge clk) disable iff (!rst_q)
    rsp_err |-> rsp_valid);

  assert_one_strobe_R8: assert property (@(posedge clk) disable iff (!rst_q)
    $onehot0({cmd_start, cmd_append, cmd_reset}));

  assert_strobe_from_write_R8: assert property (@(posedge clk) disable iff (!rst_q)
    host_valid && !host_write |=> !(cmd_start || cmd_append || cmd_reset));

  assert_range_err_R2: assert property (@(posedge clk) disable iff (!rst_q)
    (host_valid && (host_addr[ADDR_W-1:WIN_SHIFT] > LAST_WIN)) |=> rsp_err);

  assert_low_unmapped_R1: assert property (@(posedge clk) disable iff (!rst_q)
    (host_valid && (host_addr[ADDR_W-1:WIN_SHIFT] == '0)) |=> rsp_err);
endmodule

// File: tb/dmac_regbank_test.sv
module dmac_regbank_test;
  localparam int NUM_CH = 4;
  localparam int ADDR_W = 12;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_valid, host_write;
  logic [11:0] host_addr;
  logic [3:0]  host_bytes;
  logic [63:0] host_wdata;
  logic        rsp_valid, rsp_err;
  logic [63:0] rsp_rdata;
  logic        cmd_start, cmd_append, cmd_reset;
  logic [1:0]  cmd_chan;
  logic        seq_stat_valid, seq_err_valid;
  logic [1:0]  seq_stat_chan, seq_err_chan;
  logic [63:0] seq_stat_data;
  logic [31:0] seq_err_bits;

  always #10 clk = ~clk;

  dmac_regbank #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .host_valid(host_valid), .host_write(host_write), .host_addr(host_addr),
    .host_bytes(host_bytes), .host_wdata(host_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .cmd_start(cmd_start), .cmd_append(cmd_append), .cmd_reset(cmd_reset),
    .cmd_chan(cmd_chan),
    .seq_stat_valid(seq_stat_valid), .seq_stat_chan(seq_stat_chan),
    .seq_stat_data(seq_stat_data),
    .seq_err_valid(seq_err_valid), .seq_err_chan(seq_err_chan),
    .seq_err_bits(seq_err_bits)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic        s_valid, s_err, s_start, s_append, s_reset;
  logic [63:0] s_data;
  logic [1:0]  s_chan;

  function automatic logic [11:0] ra(int ch, logic [6:0] ofs);
    return 12'((ch + 1) * 128) | {5'd0, ofs};
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // caller sits at a falling edge; returns at the next falling edge
  task automatic access(logic wr, logic [11:0] a, logic [3:0] n, logic [63:0] d);
    host_valid = 1'b1; host_write = wr; host_addr = a; host_bytes = n; host_wdata = d;
    @(posedge clk); @(negedge clk);
    s_valid = rsp_valid; s_err = rsp_err; s_data = rsp_rdata;
    s_start = cmd_start; s_append = cmd_append; s_reset = cmd_reset; s_chan = cmd_chan;
    host_valid = 1'b0; host_write = 1'b0;
  endtask

  task automatic seq_stat(logic [1:0] ch, logic [63:0] d);
    seq_stat_valid = 1'b1; seq_stat_chan = ch; seq_stat_data = d;
    @(posedge clk); @(negedge clk);
    seq_stat_valid = 1'b0;
  endtask

  task automatic seq_err(logic [1:0] ch, logic [31:0] b);
    seq_err_valid = 1'b1; seq_err_chan = ch; seq_err_bits = b;
    @(posedge clk); @(negedge clk);
    seq_err_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R10", "idle rsp_valid", {63'd0, rsp_valid}, 64'd0);
    access(1'b0, ra(0, 7'h00), 4'd2, '0);
    chk("R10", "rsp_valid", {63'd0, s_valid}, 64'd1);
    chk("R7",  "ctrl reset value", s_data, 64'h1);
    access(1'b0, ra(3, 7'h08), 4'd8, '0);
    chk("R10", "status reset value", s_data, 64'd0);
    access(1'b0, ra(1, 7'h20), 4'd4, '0);
    chk("R10", "error reset value", s_data, 64'd0);
  endtask

  task automatic t_decode;
    access(1'b1, ra(2, 7'h10), 4'd8, 64'h0123_4567_89AB_CDEF);
    chk("R1", "write err", {63'd0, s_err}, 64'd0);
    access(1'b0, ra(2, 7'h10), 4'd8, '0);
    chk("R1", "chain ch2 readback", s_data, 64'h0123_4567_89AB_CDEF);
    access(1'b0, ra(1, 7'h10), 4'd8, '0);
    chk("R1", "chain ch1 untouched", s_data, 64'd0);
    access(1'b0, 12'h010, 4'd8, '0);
    chk("R1", "window 0 err", {63'd0, s_err}, 64'd1);
    access(1'b0, ra(0, 7'h0C), 4'd4, '0);
    chk("R1", "hole offset err", {63'd0, s_err}, 64'd1);
  endtask

  task automatic t_range;
    access(1'b1, 12'h290, 4'd8, 64'hFFFF);
    chk("R2", "ch4 err", {63'd0, s_err}, 64'd1);
    chk("R2", "ch4 rdata", s_data, 64'd0);
    access(1'b1, ra(3, 7'h10), 4'd4, 64'h55);
    chk("R2", "ch3 ok", {63'd0, s_err}, 64'd0);
    access(1'b0, ra(3, 7'h10), 4'd8, '0);
    chk("R2", "ch3 chain", s_data, 64'h55);
  endtask

  task automatic t_size;
    access(1'b0, ra(0, 7'h20), 4'd3, '0);
    chk("R3", "size 3 err", {63'd0, s_err}, 64'd1);
    access(1'b1, ra(0, 7'h00), 4'd4, 64'hFFF0);
    chk("R3", "ctrl size4 err", {63'd0, s_err}, 64'd1);
    access(1'b0, ra(0, 7'h00), 4'd2, '0);
    chk("R3", "ctrl unchanged", s_data, 64'h1);
    access(1'b1, ra(0, 7'h04), 4'd2, 64'h01);
    chk("R3", "cmd size2 err", {63'd0, s_err}, 64'd1);
    chk("R3", "cmd size2 no start", {63'd0, s_start}, 64'd0);
    access(1'b0, ra(0, 7'h14), 4'd8, '0);
    chk("R3", "chain hi size8 err", {63'd0, s_err}, 64'd1);
  endtask

  task automatic t_ptr;
    access(1'b1, ra(1, 7'h18), 4'd8, 64'h1122_3344_5566_7788);
    access(1'b1, ra(1, 7'h18), 4'd4, 64'hAAAA_BBBB);
    access(1'b0, ra(1, 7'h18), 4'd8, '0);
    chk("R4", "low half write", s_data, 64'h1122_3344_AAAA_BBBB);
    access(1'b1, ra(1, 7'h1C), 4'd4, 64'hCCCC_DDDD);
    access(1'b0, ra(1, 7'h18), 4'd8, '0);
    chk("R4", "high half write", s_data, 64'hCCCC_DDDD_AAAA_BBBB);
    access(1'b0, ra(1, 7'h1C), 4'd4, '0);
    chk("R4", "high half read", s_data, 64'hCCCC_DDDD);
    access(1'b0, ra(1, 7'h18), 4'd4, '0);
    chk("R4", "low half read", s_data, 64'hAAAA_BBBB);
  endtask

  task automatic t_status;
    seq_stat(2'd0, 64'hDEAD_0000_0000_00F5);
    access(1'b0, ra(0, 7'h08), 4'd8, '0);
    chk("R5", "seq update", s_data, 64'hDEAD_0000_0000_00F5);
    access(1'b1, ra(0, 7'h08), 4'd8, 64'h0);
    chk("R5", "status write no err", {63'd0, s_err}, 64'd0);
    access(1'b0, ra(0, 7'h08), 4'd8, '0);
    chk("R5", "status write ignored", s_data, 64'hDEAD_0000_0000_00F5);
  endtask

  task automatic t_err;
    seq_err(2'd3, 32'h0000_F0F0);
    access(1'b1, ra(3, 7'h20), 4'd4, 64'h00F0);
    access(1'b0, ra(3, 7'h20), 4'd4, '0);
    chk("R6", "w1c", s_data, 64'hF000);
    seq_err_valid = 1'b1; seq_err_chan = 2'd3; seq_err_bits = 32'h8001;
    access(1'b1, ra(3, 7'h20), 4'd4, 64'hF000);
    seq_err_valid = 1'b0;
    access(1'b0, ra(3, 7'h20), 4'd4, '0);
    chk("R6", "w1c with same-cycle set", s_data, 64'h8001);
  endtask

  task automatic t_ctrl;
    access(1'b1, ra(2, 7'h00), 4'd2, 64'h00A0);
    access(1'b0, ra(2, 7'h00), 4'd2, '0);
    chk("R7", "zero keeps idis", s_data, 64'h00A1);
    access(1'b1, ra(2, 7'h00), 4'd2, 64'h0001);
    access(1'b0, ra(2, 7'h00), 4'd2, '0);
    chk("R7", "one clears idis", s_data, 64'h0000);
    access(1'b1, ra(2, 7'h00), 4'd2, 64'h0000);
    access(1'b0, ra(2, 7'h00), 4'd2, '0);
    chk("R7", "stays clear", s_data, 64'h0000);
  endtask

  task automatic t_cmd;
    seq_stat(2'd2, 64'h77);
    access(1'b1, ra(2, 7'h04), 4'd1, 64'h01);
    chk("R8", "start strobe", {61'd0, s_start, s_append, s_reset}, 64'b100);
    chk("R8", "start chan", {62'd0, s_chan}, 64'd2);
    access(1'b0, ra(2, 7'h08), 4'd8, '0);
    chk("R8", "start field", s_data, 64'h70);
    access(1'b1, ra(1, 7'h04), 4'd1, 64'h20);
    chk("R8", "reset strobe", {61'd0, s_start, s_append, s_reset}, 64'b001);
    chk("R8", "reset chan", {62'd0, s_chan}, 64'd1);
    access(1'b0, ra(1, 7'h08), 4'd8, '0);
    chk("R8", "reset field", s_data, 64'h3);
    access(1'b1, ra(3, 7'h04), 4'd1, 64'h22);
    chk("R8", "append over reset", {61'd0, s_start, s_append, s_reset}, 64'b010);
    chk("R8", "append chan", {62'd0, s_chan}, 64'd3);
    access(1'b1, ra(0, 7'h04), 4'd1, 64'h23);
    chk("R8", "start over all", {61'd0, s_start, s_append, s_reset}, 64'b100);
    access(1'b0, ra(0, 7'h04), 4'd1, '0);
    chk("R8", "cmd readback", s_data, 64'h23);
    seq_stat_valid = 1'b1; seq_stat_chan = 2'd0; seq_stat_data = 64'hABCD_0007;
    access(1'b1, ra(0, 7'h04), 4'd1, 64'h01);
    seq_stat_valid = 1'b0;
    access(1'b0, ra(0, 7'h08), 4'd8, '0);
    chk("R8", "start over same-cycle update", s_data, 64'hABCD_0000);
  endtask

  task automatic t_badcmd;
    access(1'b1, ra(0, 7'h04), 4'd1, 64'h05);
    chk("R9", "suspend err", {63'd0, s_err}, 64'd1);
    chk("R9", "suspend no strobe", {61'd0, s_start, s_append, s_reset}, 64'd0);
    access(1'b1, ra(0, 7'h04), 4'd1, 64'h10);
    chk("R9", "resume err", {63'd0, s_err}, 64'd1);
    access(1'b1, ra(0, 7'h04), 4'd1, 64'h08);
    chk("R9", "abort err", {63'd0, s_err}, 64'd1);
    access(1'b0, ra(0, 7'h04), 4'd1, '0);
    chk("R9", "cmd reg unchanged", s_data, 64'h01);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    host_valid = 1'b0; host_write = 1'b0; host_addr = '0; host_bytes = '0; host_wdata = '0;
    seq_stat_valid = 1'b0; seq_stat_chan = '0; seq_stat_data = '0;
    seq_err_valid = 1'b0; seq_err_chan = '0; seq_err_bits = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_decode();
    t_range();
    t_size();
    t_ptr();
    t_status();
    t_err();
    t_ctrl();
    t_cmd();
    t_badcmd();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule